// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block collects 64 interrupt sources and selects the one to present to a processor interface. Lines 0 to 15 are raised only by software, lines 16 to 31 are private hardware inputs with a fixed level trigger, and lines 32 to 63 are shared hardware inputs whose trigger is chosen per line. For each line the block holds an enable bit, a pending bit, a 4-bit priority and a processor target mask. Software reaches all of this through a plain 32-bit register port with byte strobes.

All pending and enabled lines are compared every cycle. The most urgent one is driven out as an ID, a priority and a target mask, gated by one global enable bit. Register reads are combinational from the address. Register writes take effect at the next rising clock edge.

Top module: `irq_dist`

## Requirements
- R1: Bit 0 of the word at 0x000 is the global forwarding enable and reads back. While it is 0, `cand_valid` is low whatever lines are pending.
- R2: The word at 0x004 is read-only. It holds (line count/32 − 1) in bits 4:0 and (processor count − 1) in bits 7:5, which reads 0x000000E1 with the default sizes.
- R3: Enable bits are set through the words at 0x100 + 4k and cleared through the words at 0x180 + 4k. Pending bits are set through 0x200 + 4k and cleared through 0x280 + 4k. Word k covers lines 32k to 32k+31, with bit n for line 32k+n. A 1 in the write data acts and a 0 leaves the bit alone. Reading either word of a pair returns the current state.
- R4: The priority of line ID sits in byte 0x400 + ID, where byte lane = ID mod 4. Only bits 7:4 are stored, and bits 3:0 read as 0. Bytes for IDs 64 and above read 0 and ignore writes. Only the lanes whose byte strobe is set are written.
- R5: The target mask of line ID sits in byte 0x800 + ID. For IDs 16–63 it reads and writes normally. For IDs 0–15 it reads the target list gathered by software-interrupt writes, and writes to it are ignored.
- R6: The trigger words at 0xC00 + 4k give each line 2 bits, with line ID at bits 2·(ID mod 16)+1 : 2·(ID mod 16) of word ID/16. For IDs 32–63, bit 1 set selects rising edge and bit 1 clear selects level-high. Bit 0 always reads 0. IDs 0–15 read 0b10 and IDs 16–31 read 0b00, and writes to either group are ignored, so a private line stays level-sensitive.
- R7: An edge line becomes pending one clock after a 0→1 change of its input. It stays pending until it is cleared, even if the input falls, and a clear while the input stays high keeps it clear. A level line reads pending whenever its input is high, in the same cycle. A software set on a level line keeps it pending after the input falls, until a clear-pending write.
- R8: A write to 0xF00 takes a software-interrupt ID from bits 3:0 and a processor list from bits 23:16 (bit 16 + p names processor p). If the list is non-zero, the line becomes pending and the list is ORed into that line's gathered targets. If the list is zero, nothing changes. Clearing the line's pending bit empties its gathered targets.
- R9: The candidate is the pending and enabled line with the numerically lowest priority, and the lowest ID wins a tie. `cand_prio` carries its 4-bit priority and `cand_tgt` carries its target mask (the gathered list for IDs 0–15).
- R10: After reset every enable, pending, priority, target, trigger and control bit is 0 and `cand_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register word (word aligned) |
| bus_be | input | 4 | Byte strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_irq | input | 48 | Hardware inputs; bit n feeds line ID n+16 |
| cand_valid | output | 1 | A line is being forwarded |
| cand_id | output | 6 | ID of the forwarded line |
| cand_prio | output | 4 | Priority of the forwarded line |
| cand_tgt | output | 8 | Target mask of the forwarded line |

## Verification
A wrong pending or enable bit shows up in two places. It reads back through the pending or enable words straight after the write or input edge that caused it. It also changes the candidate in that same cycle, because selection is combinational from the stored state. A wrong priority or tie-break shows on `cand_id` as soon as two enabled lines are pending together. A lost or leaked software-interrupt target appears both in the target byte and in `cand_tgt` one clock after the 0xF00 write.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int LINES_DEF = 64;
    localparam int CPUS_DEF  = 8;
    localparam int PRIO_DEF  = 4;
    localparam int SGI_N     = 16;
    localparam int PPI_N     = 16;

    typedef enum logic [1:0] {
        KIND_SGI,
        KIND_PPI,
        KIND_SPI
    } kind_e;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPEND,
        RG_CLRPEND,
        RG_PRIO,
        RG_TGT,
        RG_CFG,
        RG_SGI
    } region_e;

    function automatic kind_e kind_of(int id);
        if (id < SGI_N)
            return KIND_SGI;
        if (id < SGI_N + PPI_N)
            return KIND_PPI;
        return KIND_SPI;
    endfunction

    function automatic region_e decode(logic [11:0] a);
        if (a[1:0] != 2'b00)        return RG_NONE;
        if (a[11:2] == 10'h000)     return RG_CTRL;
        if (a[11:2] == 10'h001)     return RG_TYPE;
        if (a[11:7] == 5'b00010)    return RG_SETEN;
        if (a[11:7] == 5'b00011)    return RG_CLREN;
        if (a[11:7] == 5'b00100)    return RG_SETPEND;
        if (a[11:7] == 5'b00101)    return RG_CLRPEND;
        if (a[11:10] == 2'b01)      return RG_PRIO;
        if (a[11:10] == 2'b10)      return RG_TGT;
        if (a[11:8] == 4'hC)        return RG_CFG;
        if (a[11:2] == 10'h3C0)     return RG_SGI;
        return RG_NONE;
    endfunction

    function automatic logic [31:0] type_word(int lines, int cpus);
        return (32'(cpus - 1) << 5) | 32'(lines / 32 - 1);
    endfunction

endpackage

// File: rtl/irq_dist_line.sv
module irq_dist_line
    import irq_dist_pkg::*;
#(
    parameter kind_e KIND = KIND_SPI
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_in,
    input  logic edge_sel,
    input  logic sw_set,
    input  logic sw_clr,
    output logic pending
);
    logic prev_q;
    logic latch_q;
    logic is_edge;
    logic rise;

    generate
        if (KIND == KIND_SGI) begin : g_sgi
            assign is_edge = 1'b1 | edge_sel;
        end else if (KIND == KIND_PPI) begin : g_ppi
            assign is_edge = 1'b0 & edge_sel;
        end else begin : g_spi
            assign is_edge = edge_sel;
        end
    endgenerate

    assign rise = is_edge & hw_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= hw_in;
            if (rise || sw_set)
                latch_q <= 1'b1;
            else if (sw_clr)
                latch_q <= 1'b0;
        end
    end

    assign pending = latch_q | (~is_edge & hw_in);

endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb #(
    parameter int N   = 64,
    parameter int P_W = 4,
    parameter int IW  = 6
) (
    input  logic [N-1:0]   req,
    input  logic [P_W-1:0] prio [N],
    output logic           win_valid,
    output logic [IW-1:0]  win_id,
    output logic [P_W-1:0] win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!win_valid || prio[i] < win_prio)) begin
                win_valid = 1'b1;
                win_id    = IW'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
    import irq_dist_pkg::*;
#(
    parameter int N_LINES = LINES_DEF,
    parameter int N_CPUS  = CPUS_DEF,
    parameter int P_W     = PRIO_DEF,
    localparam int IW     = $clog2(N_LINES),
    localparam int NW     = N_LINES / 32,
    localparam int HW_N   = N_LINES - SGI_N,
    localparam int SW     = $clog2(SGI_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [HW_N-1:0]   hw_irq,
    output logic              cand_valid,
    output logic [IW-1:0]     cand_id,
    output logic [P_W-1:0]    cand_prio,
    output logic [N_CPUS-1:0] cand_tgt
);
    region_e               rg;
    logic                  ctrl_en;
    logic [N_LINES-1:0]    en_q;
    logic [N_LINES-1:0]    edge_cfg_q;
    logic [N_LINES-1:0]    pend;
    logic [N_LINES-1:0]    set_pend;
    logic [N_LINES-1:0]    clr_pend;
    logic [N_LINES-1:0]    hw_vec;
    logic [P_W-1:0]        prio_q  [N_LINES];
    logic [N_CPUS-1:0]     tgt_q   [N_LINES];
    logic [N_CPUS-1:0]     sgi_tgt [SGI_N];
    logic [31:0]           bmask;
    logic [31:0]           wbits;
    logic [4:0]            widx;
    logic [N_CPUS-1:0]     sgi_list;
    logic [SGI_N-1:0]      sgi_hit;
    logic                  win_valid;
    logic [IW-1:0]         win_id;
    logic [P_W-1:0]        win_prio;

    assign rg       = decode(bus_addr);
    assign widx     = bus_addr[6:2];
    assign hw_vec   = {hw_irq, {SGI_N{1'b0}}};
    assign sgi_list = bus_wdata[16 +: N_CPUS];

    always_comb begin
        for (int b = 0; b < 4; b++)
            bmask[b*8 +: 8] = {8{bus_be[b]}};
        wbits = bus_wdata & bmask;
    end

    // Software set/clear pulses, including software-interrupt requests
    always_comb begin
        set_pend = '0;
        clr_pend = '0;
        for (int w = 0; w < NW; w++) begin
            if (bus_wr && rg == RG_SETPEND && widx == 5'(w))
                set_pend[w*32 +: 32] = wbits;
            if (bus_wr && rg == RG_CLRPEND && widx == 5'(w))
                clr_pend[w*32 +: 32] = wbits;
        end
        for (int s = 0; s < SGI_N; s++) begin
            sgi_hit[s]  = bus_wr && rg == RG_SGI && (|sgi_list)
                          && bus_wdata[SW-1:0] == SW'(s);
            set_pend[s] = set_pend[s] | sgi_hit[s];
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irq_dist_line #(.KIND(kind_of(g))) u_line (
            .clk      (clk),
            .rst      (rst),
            .hw_in    (hw_vec[g]),
            .edge_sel (edge_cfg_q[g]),
            .sw_set   (set_pend[g]),
            .sw_clr   (clr_pend[g]),
            .pending  (pend[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en    <= 1'b0;
            en_q       <= '0;
            edge_cfg_q <= '0;
            for (int i = 0; i < N_LINES; i++) begin
                prio_q[i] <= '0;
                tgt_q[i]  <= '0;
            end
        end else if (bus_wr) begin
            case (rg)
                RG_CTRL: if (bus_be[0]) ctrl_en <= bus_wdata[0];
                RG_SETEN:
                    for (int w = 0; w < NW; w++)
                        if (widx == 5'(w))
                            en_q[w*32 +: 32] <= en_q[w*32 +: 32] | wbits;
                RG_CLREN:
                    for (int w = 0; w < NW; w++)
                        if (widx == 5'(w))
                            en_q[w*32 +: 32] <= en_q[w*32 +: 32] & ~wbits;
                RG_PRIO:
                    for (int i = 0; i < N_LINES; i++)
                        if (bus_addr[9:2] == 8'(i / 4) && bus_be[i % 4])
                            prio_q[i] <= bus_wdata[(i % 4)*8 + 8 - P_W +: P_W];
                RG_TGT:
                    for (int i = SGI_N; i < N_LINES; i++)
                        if (bus_addr[9:2] == 8'(i / 4) && bus_be[i % 4])
                            tgt_q[i] <= bus_wdata[(i % 4)*8 +: N_CPUS];
                RG_CFG:
                    for (int i = SGI_N + PPI_N; i < N_LINES; i++)
                        if (bus_addr[7:2] == 6'(i / 16) && bus_be[(i % 16) / 4])
                            edge_cfg_q[i] <= bus_wdata[(i % 16)*2 + 1];
                default: ;
            endcase
        end
    end

    // Gathered software-interrupt target lists
    always_ff @(posedge clk) begin
        for (int s = 0; s < SGI_N; s++) begin
            if (rst)
                sgi_tgt[s] <= '0;
            else if (sgi_hit[s])
                sgi_tgt[s] <= sgi_tgt[s] | sgi_list;
            else if (clr_pend[s])
                sgi_tgt[s] <= '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (rg)
            RG_CTRL: bus_rdata[0] = ctrl_en;
            RG_TYPE: bus_rdata = type_word(N_LINES, N_CPUS);
            RG_SETEN, RG_CLREN:
                for (int w = 0; w < NW; w++)
                    if (widx == 5'(w)) bus_rdata = en_q[w*32 +: 32];
            RG_SETPEND, RG_CLRPEND:
                for (int w = 0; w < NW; w++)
                    if (widx == 5'(w)) bus_rdata = pend[w*32 +: 32];
            RG_PRIO:
                for (int i = 0; i < N_LINES; i++)
                    if (bus_addr[9:2] == 8'(i / 4))
                        bus_rdata[(i % 4)*8 + 8 - P_W +: P_W] = prio_q[i];
            RG_TGT: begin
                for (int i = 0; i < SGI_N; i++)
                    if (bus_addr[9:2] == 8'(i / 4))
                        bus_rdata[(i % 4)*8 +: N_CPUS] = sgi_tgt[i];
                for (int i = SGI_N; i < N_LINES; i++)
                    if (bus_addr[9:2] == 8'(i / 4))
                        bus_rdata[(i % 4)*8 +: N_CPUS] = tgt_q[i];
            end
            RG_CFG:
                for (int i = 0; i < N_LINES; i++)
                    if (bus_addr[7:2] == 6'(i / 16))
                        bus_rdata[(i % 16)*2 + 1] =
                            (kind_of(i) == KIND_SGI) ? 1'b1 :
                            (kind_of(i) == KIND_PPI) ? 1'b0 : edge_cfg_q[i];
            default: ;
        endcase
    end

    irq_dist_arb #(.N(N_LINES), .P_W(P_W), .IW(IW)) u_arb (
        .req       (pend & en_q),
        .prio      (prio_q),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    assign cand_valid = win_valid & ctrl_en;
    assign cand_id    = cand_valid ? win_id : '0;
    assign cand_prio  = cand_valid ? win_prio : '0;
    always_comb begin
        if (!cand_valid)
            cand_tgt = '0;
        else if (int'(win_id) < SGI_N)
            cand_tgt = sgi_tgt[win_id[SW-1:0]];
        else
            cand_tgt = tgt_q[win_id];
    end

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
    parameter int N   = 64,
    parameter int P_W = 4,
    parameter int IW  = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_wr,
    input logic [11:0]    bus_addr,
    input logic [3:0]     bus_be,
    input logic [31:0]    bus_wdata,
    input logic [31:0]    bus_rdata,
    input logic           ctrl_en,
    input logic [N-1:0]   en_q,
    input logic [N-1:0]   pend,
    input logic [P_W-1:0] prio_q [N],
    input logic           cand_valid,
    input logic [IW-1:0]  cand_id,
    input logic [P_W-1:0] cand_prio
);
    logic better;

    always_comb begin
        better = 1'b0;
        for (int i = 0; i < N; i++)
            if (pend[i] && en_q[i] &&
                (prio_q[i] < cand_prio || (prio_q[i] == cand_prio && IW'(i) < cand_id)))
                better = 1'b1;
    end

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> !cand_valid);

    // R9
    cand_live_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (pend[cand_id] && en_q[cand_id]));

    // R9
    cand_best_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> !better);

    // R3
    set_en_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h100 && bus_be[0] && bus_wdata[0]) |=> en_q[0]);

    // R8
    sgi_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'hF00 && bus_wdata[16]) |=> pend[$past(bus_wdata[3:0])]);

    // R4
    prio_low_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[11:10] == 2'b01) |-> ((bus_rdata & 32'h0F0F0F0F) == 32'h0));

endmodule

bind irq_dist irq_dist_chk #(.N(N_LINES), .P_W(P_W), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ctrl_en    (ctrl_en),
    .en_q       (en_q),
    .pend       (pend),
    .prio_q     (prio_q),
    .cand_valid (cand_valid),
    .cand_id    (cand_id),
    .cand_prio  (cand_prio)
);

// File: tb/sim_irq_dist.sv
module sim_irq_dist;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [47:0] hw_irq;
    logic        cand_valid;
    logic [5:0]  cand_id;
    logic [3:0]  cand_prio;
    logic [7:0]  cand_tgt;

    int errs  = 0;
    int nchk  = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_dist u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_irq(hw_irq), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_prio(cand_prio), .cand_tgt(cand_tgt)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [11:0] ra;
        logic [31:0] ex;
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t TBL [13] = '{
        '{12'h000, 32'h1,        4'hF, 12'h000, 32'h1,        8'd1}, // R1
        '{12'h000, 32'h1,        4'hF, 12'h004, 32'hE1,       8'd2}, // R2
        '{12'h100, 32'hF0,       4'hF, 12'h100, 32'hF0,       8'd3}, // R3
        '{12'h180, 32'h30,       4'hF, 12'h180, 32'hC0,       8'd3}, // R3
        '{12'h200, 32'h0,        4'hF, 12'h200, 32'h0,        8'd3}, // R3
        '{12'h400, 32'hFFFFFFFF, 4'h5, 12'h400, 32'h00F000F0, 8'd4}, // R4
        '{12'h440, 32'hFFFFFFFF, 4'hF, 12'h440, 32'h0,        8'd4}, // R4
        '{12'h824, 32'h04030201, 4'hF, 12'h824, 32'h04030201, 8'd5}, // R5
        '{12'h800, 32'hFFFFFFFF, 4'hF, 12'h800, 32'h0,        8'd5}, // R5
        '{12'hC04, 32'hFFFFFFFF, 4'hF, 12'hC04, 32'h0,        8'd6}, // R6
        '{12'hC00, 32'h0,        4'hF, 12'hC00, 32'hAAAAAAAA, 8'd6}, // R6
        '{12'hC08, 32'hFFFFFFFF, 4'hF, 12'hC08, 32'hAAAAAAAA, 8'd6}, // R6
        '{12'hC08, 32'h0,        4'hF, 12'hC08, 32'h0,        8'd6}  // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic cand(input string tag, input logic v, input logic [5:0] id,
                        input logic [3:0] p, input logic [7:0] t);
        #1;
        check(tag, {13'h0, cand_valid, cand_id, cand_prio, cand_tgt},
                   {13'h0, v, id, p, t});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0; hw_irq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd("R10 ctrl", 12'h000, 32'h0);
        rd("R10 enable", 12'h100, 32'h0);
        rd("R10 pending", 12'h200, 32'h0);
        cand("R10 candidate", 1'b0, 6'd0, 4'd0, 8'h0);

        foreach (TBL[k]) begin
            wr(TBL[k].wa, TBL[k].wd, TBL[k].be);
            rd($sformatf("R%0d vector %0d", TBL[k].rq, k), TBL[k].ra, TBL[k].ex);
        end

        // R8 software interrupt 6 to processors 0,1
        wr(12'hF00, 32'h0003_0006, 4'hF);
        rd("R8 sgi pending", 12'h200, 32'h40);
        rd("R5 sgi gathered targets", 12'h804, 32'h0003_0000);
        cand("R9 sgi candidate", 1'b1, 6'd6, 4'd0, 8'h03);
        wr(12'hF00, 32'h0000_0005, 4'hF);
        rd("R8 empty list ignored", 12'h200, 32'h40);
        wr(12'hF00, 32'h0080_0006, 4'hF);
        rd("R8 targets accumulate", 12'h804, 32'h0083_0000);
        wr(12'h280, 32'h40, 4'hF);
        rd("R3 clear pending", 12'h200, 32'h0);
        rd("R8 clear empties list", 12'h804, 32'h0);
        cand("R9 nothing pending", 1'b0, 6'd0, 4'd0, 8'h0);

        // R7 edge line 40 (hw_irq[24])
        wr(12'hC08, 32'h1 << 17, 4'hF);
        wr(12'h104, 32'h100, 4'hF);
        wr(12'h428, 32'h50, 4'h1);
        rd("R3 enable word 1", 12'h104, 32'h100);
        @(negedge clk); hw_irq[24] = 1'b1;
        @(negedge clk); hw_irq[24] = 1'b0;
        rd("R7 edge latched", 12'h204, 32'h100);
        cand("R9 edge candidate", 1'b1, 6'd40, 4'd5, 8'h0);
        wr(12'h284, 32'h100, 4'hF);
        rd("R7 edge cleared", 12'h204, 32'h0);
        @(negedge clk); hw_irq[24] = 1'b1;
        @(negedge clk);
        wr(12'h284, 32'h100, 4'hF);
        repeat (2) @(negedge clk);
        rd("R7 held high no re-trigger", 12'h204, 32'h0);
        hw_irq[24] = 1'b0;

        // R7 level line 41 (hw_irq[25])
        wr(12'h104, 32'h200, 4'hF);
        wr(12'h428, 32'h5000, 4'h2);
        @(negedge clk); hw_irq[25] = 1'b1;
        rd("R7 level follows high", 12'h204, 32'h200);
        cand("R9 level candidate", 1'b1, 6'd41, 4'd5, 8'h0);
        wr(12'h204, 32'h100, 4'hF);
        cand("R9 tie lowest id", 1'b1, 6'd40, 4'd5, 8'h0);
        wr(12'h428, 32'h3000, 4'h2);
        cand("R9 lower value wins", 1'b1, 6'd41, 4'd3, 8'h0);
        @(negedge clk); hw_irq[25] = 1'b0;
        rd("R7 level follows low", 12'h204, 32'h100);
        wr(12'h204, 32'h200, 4'hF);
        rd("R7 level software set", 12'h204, 32'h300);
        wr(12'h284, 32'h200, 4'hF);
        rd("R7 level software clear", 12'h204, 32'h100);

        // R1 global gate
        wr(12'h000, 32'h0, 4'hF);
        cand("R1 gate off", 1'b0, 6'd0, 4'd0, 8'h0);
        wr(12'h000, 32'h1, 4'hF);
        cand("R1 gate on", 1'b1, 6'd40, 4'd5, 8'h0);

        // R3 disabled line not forwarded, pending kept
        wr(12'h184, 32'h100, 4'hF);
        cand("R3 disabled line", 1'b0, 6'd0, 4'd0, 8'h0);
        rd("R3 pending kept", 12'h204, 32'h100);

        // R6 private line 16 stays level despite config write
        @(negedge clk); hw_irq[0] = 1'b1;
        rd("R6 private high", 12'h200, 32'h0001_0000);
        @(negedge clk); hw_irq[0] = 1'b0;
        rd("R6 private level", 12'h200, 32'h0);

        // R5 / R9 target mask on candidate
        wr(12'h828, 32'hA5, 4'h1);
        wr(12'h104, 32'h100, 4'hF);
        cand("R9 candidate targets", 1'b1, 6'd40, 4'd5, 8'hA5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule